// File: doc/BRIEF.md
# Load/Store Alignment Unit

This block sits between an integer pipeline and a 32-bit big-endian data memory. It forms the effective address of an integer load or store. Two addressing modes are supported: base register plus a sign-extended 16-bit displacement, or base register plus an index register. When the base field names register 0 in displacement mode, the base reads as literal zero.

For loads, the unit takes the memory word at the aligned address, picks the addressed byte, half-word or word using big-endian lane order, and extends it with zeros or with the sign bit. For stores, it replicates the low byte or low half-word of the source register onto the addressed lanes and raises write enables on exactly those lanes.

The memory word and the store source are presented in the same cycle as the request. All results appear registered one clock later. Half-word and word accesses that are not naturally aligned raise a flag. They are otherwise handled on the naturally aligned lanes that contain the address.

Top module: `ldst_align_unit`

## Requirements
- R1: In displacement mode (`addr_indexed`=0), `eff_addr` = base + the 16-bit `disp_imm` sign-extended to 32 bits, modulo 2^32.
- R2: In displacement mode with `base_zero`=1 the base is taken as 0. In indexed mode `base_zero` has no effect and `base_val` is used.
- R3: In indexed mode (`addr_indexed`=1), `eff_addr` = `base_val` + `index_val`, modulo 2^32.
- R4: Access size is encoded on `acc_size` as 00 = byte, 01 = half-word, 10 or 11 = word. Memory is big-endian: byte offset k (k = `eff_addr[1:0]`) is `mem_word[31-8k:24-8k]`. A half-word load at offset 0 returns `mem_word[31:16]`, and at offset 2 it returns `mem_word[15:0]`.
- R5: A load with `sign_mode`=0 returns the selected byte or half-word with all upper bits 0.
- R6: A load with `sign_mode`=1 fills the upper bits with the most significant bit of the selected byte or half-word. Word loads are unaffected by `sign_mode`.
- R7: A store (`is_store`=1) drives `lane_we[j]`=1 only for the lanes it writes. Lane j covers `wr_data[8j+7:8j]`, so byte offset k is lane 3-k. The low byte or low half-word of `store_src` (the whole word for word stores) is placed on those lanes in big-endian order. Lanes that are not written carry 0.
- R8: A load drives `lane_we`=0 and `wr_data`=0. A store drives `ld_data`=0.
- R9: `misalign` is 1 for a half-word with `eff_addr[0]`=1, or a word with `eff_addr[1:0]`≠0. In that case the lanes used are those of the naturally aligned half-word or word that contains the address, and `eff_addr` is reported unmodified.
- R10: All outputs are registered. The results for a request with `req_valid`=1 appear one clock later with `rsp_valid`=1. After a cycle with `req_valid`=0, and during synchronous reset `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 00 byte, 01 half-word, 1x word |
| sign_mode | input | 1 | 1 = algebraic extension on loads |
| addr_indexed | input | 1 | 1 = base + index, 0 = base + displacement |
| base_zero | input | 1 | Base field names register 0 |
| base_val | input | 32 | Base register value |
| disp_imm | input | 16 | Signed displacement |
| index_val | input | 32 | Index register value |
| mem_word | input | 32 | Memory word at the aligned address |
| store_src | input | 32 | Store source register |
| rsp_valid | output | 1 | Registered results valid |
| eff_addr | output | 32 | Effective address |
| ld_data | output | 32 | Extended load result |
| lane_we | output | 4 | Byte-lane write enables |
| wr_data | output | 32 | Store word on lanes |
| misalign | output | 1 | Misaligned access flag |

## Verification
The documented word patterns 0x12345678 and 0x87654321 are loaded at every offset and size with both extension modes. A pattern with a set sign bit in only some bytes shows whether extension looks at the selected byte rather than the word. Stores of a source whose bytes all differ, at every lane, expose wrong lane order or a wrong byte choice. Negative displacements, register-0 bases in both modes and carries across the 16-bit boundary separate the adder paths. Misaligned offsets and a long random run compare every output with a behavioural model each clock.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  function automatic logic [2:0] size_nbytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ldst_ea_gen.sv
module ldst_ea_gen #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16
) (
  input  logic              indexed,
  input  logic              base_zero,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp_imm,
  input  logic [XLEN-1:0]   index_val,
  output logic [XLEN-1:0]   ea
);
  localparam int SX_W = XLEN - DISP_W;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp_sx;
  logic [XLEN-1:0] addend;

  always_comb begin
    base_eff = (base_zero && !indexed) ? '0 : base_val;
    disp_sx  = {{SX_W{disp_imm[DISP_W-1]}}, disp_imm};
    addend   = indexed ? index_val : disp_sx;
    ea       = base_eff + addend;
  end
endmodule

// File: rtl/ldst_lane_dec.sv
module ldst_lane_dec #(
  parameter int XLEN = 32
) (
  input  logic [1:0]        acc_size,
  input  logic [XLEN/8-1:0] ea_low_unused,
  input  logic [1:0]        ea_low,
  output logic [1:0]        offset,
  output logic              misalign,
  output logic [XLEN/8-1:0] lane_mask
);
  import ldst_pkg::*;
  localparam int LANES = XLEN / 8;

  logic [2:0] nbytes;
  logic [1:0] align_mask;

  always_comb begin
    nbytes     = size_nbytes(acc_size);
    align_mask = 2'(nbytes - 3'd1);
    misalign   = (ea_low & align_mask) != 2'b00;
    offset     = ea_low & ~align_mask;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int K = LANES - 1 - j;
    always_comb begin
      lane_mask[j] = (K >= int'(offset)) && (K < int'(offset) + int'(nbytes));
    end
  end

  logic unused_ok;
  assign unused_ok = ^ea_low_unused;
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] mem_word,
  input  logic [1:0]      acc_size,
  input  logic [1:0]      offset,
  input  logic            sign_mode,
  output logic [XLEN-1:0] ld_data
);
  localparam int LANES = XLEN / 8;

  logic [7:0]  be_byte [LANES];
  logic [7:0]  b_sel;
  logic [15:0] h_sel;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign be_byte[k] = mem_word[XLEN-1-8*k -: 8];
  end

  always_comb begin
    b_sel = be_byte[offset];
    h_sel = {be_byte[offset], be_byte[2'(offset + 2'd1)]};
    case (acc_size)
      2'b00:   ld_data = {{(XLEN-8){sign_mode & b_sel[7]}}, b_sel};
      2'b01:   ld_data = {{(XLEN-16){sign_mode & h_sel[15]}}, h_sel};
      default: ld_data = mem_word;
    endcase
  end
endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   store_src,
  input  logic [1:0]        acc_size,
  input  logic [XLEN/8-1:0] lane_mask,
  output logic [XLEN-1:0]   wr_data
);
  localparam int LANES = XLEN / 8;

  logic [XLEN-1:0] rep;
  logic [XLEN-1:0] bit_mask;

  always_comb begin
    case (acc_size)
      2'b00:   rep = {LANES{store_src[7:0]}};
      2'b01:   rep = {(LANES/2){store_src[15:0]}};
      default: rep = store_src;
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign bit_mask[8*j +: 8] = {8{lane_mask[j]}};
  end

  assign wr_data = rep & bit_mask;
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              is_store,
  input  logic [1:0]        acc_size,
  input  logic              sign_mode,
  input  logic              addr_indexed,
  input  logic              base_zero,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp_imm,
  input  logic [XLEN-1:0]   index_val,
  input  logic [XLEN-1:0]   mem_word,
  input  logic [XLEN-1:0]   store_src,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   eff_addr,
  output logic [XLEN-1:0]   ld_data,
  output logic [XLEN/8-1:0] lane_we,
  output logic [XLEN-1:0]   wr_data,
  output logic              misalign
);
  localparam int LANES = XLEN / 8;

  logic [XLEN-1:0]  ea_c;
  logic [1:0]       off_c;
  logic             mis_c;
  logic [LANES-1:0] mask_c;
  logic [XLEN-1:0]  ld_c;
  logic [XLEN-1:0]  st_c;

  ldst_ea_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_ea (
    .indexed   (addr_indexed),
    .base_zero (base_zero),
    .base_val  (base_val),
    .disp_imm  (disp_imm),
    .index_val (index_val),
    .ea        (ea_c)
  );

  ldst_lane_dec #(.XLEN(XLEN)) u_dec (
    .acc_size      (acc_size),
    .ea_low_unused (ea_c[LANES-1:0]),
    .ea_low        (ea_c[1:0]),
    .offset        (off_c),
    .misalign      (mis_c),
    .lane_mask     (mask_c)
  );

  ldst_load_fmt #(.XLEN(XLEN)) u_ld (
    .mem_word  (mem_word),
    .acc_size  (acc_size),
    .offset    (off_c),
    .sign_mode (sign_mode),
    .ld_data   (ld_c)
  );

  ldst_store_fmt #(.XLEN(XLEN)) u_st (
    .store_src (store_src),
    .acc_size  (acc_size),
    .lane_mask (mask_c),
    .wr_data   (st_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      eff_addr  <= '0;
      ld_data   <= '0;
      lane_we   <= '0;
      wr_data   <= '0;
      misalign  <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      eff_addr  <= ea_c;
      misalign  <= mis_c;
      ld_data   <= is_store ? '0 : ld_c;
      lane_we   <= is_store ? mask_c : '0;
      wr_data   <= is_store ? st_c : '0;
    end
  end
endmodule

// File: rtl/ldst_align_unit_chk.sv
module ldst_align_unit_chk #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              is_store,
  input logic [1:0]        acc_size,
  input logic              sign_mode,
  input logic              rsp_valid,
  input logic [XLEN-1:0]   eff_addr,
  input logic [XLEN-1:0]   ld_data,
  input logic [XLEN/8-1:0] lane_we,
  input logic [XLEN-1:0]   wr_data,
  input logic              misalign
);
  localparam int LANES = XLEN / 8;

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (lane_we == '0 && !misalign && ld_data == '0));

  assert_load_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(is_store)) |-> (lane_we == '0 && wr_data == '0));

  assert_store_lane_count_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(is_store)) |->
      ($countones(lane_we) == int'(ldst_pkg::size_nbytes($past(acc_size)))));

  assert_word_misalign_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(acc_size[1])) |-> (misalign == (eff_addr[1:0] != 2'b00)));

  assert_zero_ext_byte_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(is_store) && !$past(sign_mode) && $past(acc_size) == 2'b00)
      |-> (ld_data[XLEN-1:8] == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    assert_unwritten_lane_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !lane_we[j] |-> (wr_data[8*j +: 8] == 8'h00));
  end
endmodule

bind ldst_align_unit ldst_align_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .is_store  (is_store),
  .acc_size  (acc_size),
  .sign_mode (sign_mode),
  .rsp_valid (rsp_valid),
  .eff_addr  (eff_addr),
  .ld_data   (ld_data),
  .lane_we   (lane_we),
  .wr_data   (wr_data),
  .misalign  (misalign)
);

// File: tb/ldst_align_unit_test.sv
module ldst_align_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        is_store = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic        sign_mode = 1'b0;
  logic        addr_indexed = 1'b0;
  logic        base_zero = 1'b0;
  logic [31:0] base_val = '0;
  logic [15:0] disp_imm = '0;
  logic [31:0] index_val = '0;
  logic [31:0] mem_word = '0;
  logic [31:0] store_src = '0;
  logic        rsp_valid;
  logic [31:0] eff_addr;
  logic [31:0] ld_data;
  logic [3:0]  lane_we;
  logic [31:0] wr_data;
  logic        misalign;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_align_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_store(is_store),
    .acc_size(acc_size), .sign_mode(sign_mode), .addr_indexed(addr_indexed),
    .base_zero(base_zero), .base_val(base_val), .disp_imm(disp_imm),
    .index_val(index_val), .mem_word(mem_word), .store_src(store_src),
    .rsp_valid(rsp_valid), .eff_addr(eff_addr), .ld_data(ld_data),
    .lane_we(lane_we), .wr_data(wr_data), .misalign(misalign)
  );

  typedef struct {
    string       tag;
    logic        v;
    logic [31:0] ea;
    logic [31:0] ld;
    logic [3:0]  we;
    logic [31:0] wd;
    logic        mis;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  function automatic exp_t model(string tag, bit st, int sz, bit sx, bit idx,
                                 bit r0, logic [31:0] b, logic [15:0] d,
                                 logic [31:0] x, logic [31:0] m, logic [31:0] s);
    exp_t e;
    logic [31:0] a;
    logic [63:0] raw;
    int n, k, sh;
    e.tag = tag;
    e.v   = 1;
    a = (r0 && !idx) ? 32'd0 : b;
    if (idx) a = a + x;
    else     a = a + {{16{d[15]}}, d};
    e.ea = a;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    k = int'(a[1:0]);
    e.mis = (k % n) != 0;
    k = k - (k % n);
    e.ld = 0; e.we = 0; e.wd = 0;
    if (!st) begin
      sh  = 32 - 8 * (k + n);
      raw = (64'(m) >> sh) & ((64'd1 << (8 * n)) - 1);
      if (sx && n < 4 && raw[8*n-1]) raw = raw | (~64'd0 << (8 * n));
      e.ld = raw[31:0];
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] byt;
        byt = 8'((s >> (8 * (n - 1 - i))) & 32'hFF);
        e.we[3 - (k + i)] = 1'b1;
        e.wd = e.wd | (32'(byt) << (8 * (3 - (k + i))));
      end
    end
    return e;
  endfunction

  task automatic check_out();
    exp_t e;
    e = exp_q.pop_front();
    n_vec++;
    if (rsp_valid !== e.v || eff_addr !== e.ea || ld_data !== e.ld ||
        lane_we !== e.we || wr_data !== e.wd || misalign !== e.mis) begin
      n_bad++;
      $display("FAIL %s: got v=%0b ea=%h ld=%h we=%b wd=%h mis=%0b, expected v=%0b ea=%h ld=%h we=%b wd=%h mis=%0b",
               e.tag, rsp_valid, eff_addr, ld_data, lane_we, wr_data, misalign,
               e.v, e.ea, e.ld, e.we, e.wd, e.mis);
    end
  endtask

  task automatic go(string tag, bit st, int sz, bit sx, bit idx, bit r0,
                    logic [31:0] b, logic [15:0] d, logic [31:0] x,
                    logic [31:0] m, logic [31:0] s);
    @(negedge clk);
    req_valid = 1; is_store = st; acc_size = 2'(sz); sign_mode = sx;
    addr_indexed = idx; base_zero = r0; base_val = b; disp_imm = d;
    index_val = x; mem_word = m; store_src = s;
    exp_q.push_back(model(tag, st, sz, sx, idx, r0, b, d, x, m, s));
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 0; is_store = 1; store_src = 32'hFFFF_FFFF; mem_word = 32'hFFFF_FFFF;
    e.tag = tag; e.v = 0; e.ea = 0; e.ld = 0; e.we = 0; e.wd = 0; e.mis = 0;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  initial begin
    exp_t e;
    // R10: reset state, request presented while reset held
    @(negedge clk);
    req_valid = 1; is_store = 1; acc_size = 2'b10; store_src = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    e.tag = "R10 reset"; e.v = 0; e.ea = 0; e.ld = 0; e.we = 0; e.wd = 0; e.mis = 0;
    exp_q.push_back(e);
    check_out();
    rst = 0;

    // R4 R5: big-endian selection, zero extension
    go("R4 byte off1",  0, 0, 0, 0, 0, 32'h2000_0000, 16'h0201, 0, 32'h1234_5678, 0);
    go("R4 byte off0",  0, 0, 0, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h1234_5678, 0);
    go("R4 half off0",  0, 1, 0, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h1234_5678, 0);
    go("R4 half off2",  0, 1, 0, 0, 0, 32'h2000_0000, 16'h0202, 0, 32'h1234_5678, 0);
    go("R4 word",       0, 2, 0, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h1234_5678, 0);
    go("R5 zx byte",    0, 0, 0, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h8765_4321, 0);
    go("R5 zx half",    0, 1, 0, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h8765_4321, 0);
    // R6: algebraic extension
    go("R6 sx byte0",   0, 0, 1, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h8765_4321, 0);
    go("R6 sx byte2",   0, 0, 1, 0, 0, 32'h2000_0000, 16'h0202, 0, 32'h8765_4321, 0);
    go("R6 sx half0",   0, 1, 1, 0, 0, 32'h2000_0000, 16'h0200, 0, 32'h8765_4321, 0);
    go("R6 sx half2",   0, 1, 1, 0, 0, 32'h2000_0000, 16'h0202, 0, 32'h8765_4321, 0);
    go("R6 sx byte3",   0, 0, 1, 0, 0, 32'h0000_0003, 16'h0000, 0, 32'h0012_7F80, 0);
    go("R6 sx word",    0, 3, 1, 0, 0, 32'h0000_0010, 16'h0000, 0, 32'h8000_0001, 0);
    // R1: displacement, negative and carrying
    go("R1 neg disp",   0, 2, 0, 0, 0, 32'h2000_1000, 16'hFFFC, 0, 32'hA5A5_A5A5, 0);
    go("R1 carry",      0, 2, 0, 0, 0, 32'h0000_FFF0, 16'h7FF0, 0, 32'h0, 0);
    // R2: register 0 base
    go("R2 r0 disp",    0, 2, 0, 0, 1, 32'h1234_0000, 16'h00C8, 0, 32'h1, 0);
    go("R2 r0 indexed", 0, 2, 0, 1, 1, 32'h2000_0000, 16'h0000, 32'h1000, 32'h2, 0);
    // R3: indexed addressing
    go("R3 indexed",    0, 1, 1, 1, 0, 32'h2000_0000, 16'h8000, 32'h0000_1002, 32'h8765_4321, 0);
    // R7: stores on every lane
    for (int k = 0; k < 4; k++)
      go("R7 st byte", 1, 0, 0, 0, 0, 32'h3000_0000, 16'(k), 0, 32'hFFFF_FFFF, 32'h1122_3344);
    go("R7 st half0",   1, 1, 0, 1, 0, 32'h3000_0000, 0, 32'h0, 32'h0, 32'h1122_3344);
    go("R7 st half2",   1, 1, 1, 1, 0, 32'h3000_0000, 0, 32'h2, 32'h0, 32'h1122_3344);
    go("R7 st word",    1, 2, 0, 0, 0, 32'h3000_0000, 16'h0004, 0, 32'h0, 32'hCAFE_F00D);
    // R8: load vs store output separation
    go("R8 load",       0, 2, 0, 0, 0, 32'h4, 16'h0, 0, 32'h5555_AAAA, 32'hFFFF_FFFF);
    go("R8 store",      1, 2, 0, 0, 0, 32'h4, 16'h0, 0, 32'h5555_AAAA, 32'h0F0F_0F0F);
    // R9: misaligned
    go("R9 half odd",   0, 1, 0, 0, 0, 32'h0, 16'h0003, 0, 32'h8765_4321, 0);
    go("R9 word off1",  0, 2, 0, 0, 0, 32'h0, 16'h0001, 0, 32'h8765_4321, 0);
    go("R9 st word 2",  1, 2, 0, 0, 0, 32'h0, 16'h0002, 0, 0, 32'h1122_3344);
    go("R9 st half 1",  1, 1, 0, 0, 0, 32'h0, 16'h0001, 0, 0, 32'h1122_3344);
    // R10: idle cycles
    idle("R10 idle");
    go("R10 after idle", 0, 0, 0, 0, 0, 32'h2, 16'h0, 0, 32'h1234_5678, 0);
    idle("R10 idle2");

    // R10: random mix against model
    for (int i = 0; i < 400; i++) begin
      go("R10 random", 1'($urandom), int'($urandom_range(0, 3)), 1'($urandom),
         1'($urandom), 1'($urandom), $urandom, 16'($urandom), $urandom,
         $urandom, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule